// File: doc/BRIEF.md
# Retire-Boundary Event Sequencer

This block decides, at the point where an instruction retires, whether the processor leaves its current flow for a handler. It gets four kinds of event. The retiring instruction can report a fault or a trap, each with its own vector. An external source can hold a maskable request with a vector. A separate line carries a non-maskable event. At each boundary the block picks at most one event. It reports the 8-bit vector, an event class and the address execution should resume at after the handler finishes. It then moves the core to privilege level 0.

Each accepted event pushes the prior privilege level, the prior interrupt-enable flag and a non-maskable marker onto a small context stack. A return-from-handler pulse pops the stack and restores that state. While a non-maskable handler is running, other asynchronous events wait. Synchronous faults and traps from the handler's own instructions are still accepted. Software sets and clears the interrupt-enable flag through a write strobe.

Top module: `evt_sequencer`

## Requirements
- R1: An event is accepted only in a cycle where `retire_vld` is 1 and `iret` is 0. A request waiting while no instruction retires produces no `take`.
- R2: When several events are eligible together, the order is fault, then trap, then non-maskable, then maskable. `take_cls` reports the winner as 0 = fault, 1 = trap, 2 = non-maskable, 3 = maskable.
- R3: The return address is `cur_pc` for a fault. It is `next_pc` for a trap, a non-maskable event and a maskable interrupt.
- R4: The vector is `fault_vec` for a fault, `trap_vec` for a trap, 2 for a non-maskable event and `irq_vec` for a maskable interrupt.
- R5: A maskable request is ignored while the enable flag `ie` is 0. A `ie_wr` pulse loads `ie_wdata` into the flag, but only in a cycle with no accepted event and no `iret`.
- R6: A rising edge on `nmi_in` is held pending whatever the state of `ie`. While `nmi_active` is 1, neither non-maskable nor maskable events are accepted, although faults and traps are. Returning from the non-maskable handler clears `nmi_active`.
- R7: Every accepted event sets `cpl` to 0. `iret` restores the level that was saved when the matching event was accepted.
- R8: Accepting a maskable interrupt clears `ie`. `iret` restores the saved `ie`.
- R9: `irq_ack` is a one-cycle pulse that appears in exactly the cycles where `take` is high with class 3.
- R10: `iret` with an empty context stack changes no state.
- R11: With all `DEPTH` stack entries in use, non-maskable and maskable events are held back. Faults and traps are still accepted, but no context is saved for them.
- R12: After reset, `take` and `irq_ack` are 0, `cpl` is `RESET_CPL`, `ie` is `RESET_IE` and `nmi_active` is 0.
- R13: All outputs are registered. `take` rises in the cycle after the boundary that accepted the event and lasts one cycle per accepted event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| retire_vld | input | 1 | An instruction completes this cycle |
| cur_pc | input | ADDR_W | Address of the retiring instruction |
| next_pc | input | ADDR_W | Address of the instruction after it |
| fault_vld | input | 1 | Retiring instruction faulted |
| fault_vec | input | 8 | Fault vector |
| trap_vld | input | 1 | Retiring instruction trapped |
| trap_vec | input | 8 | Trap vector, e.g. 3 or 128 |
| irq_req | input | 1 | Maskable request level |
| irq_vec | input | 8 | Vector of the maskable request |
| nmi_in | input | 1 | Non-maskable line, edge sensitive |
| iret | input | 1 | Return-from-handler pulse |
| ie_wr | input | 1 | Write strobe for the enable flag |
| ie_wdata | input | 1 | New enable flag value |
| take | output | 1 | Event accepted (one cycle) |
| take_vec | output | 8 | Vector of the accepted event |
| take_cls | output | 2 | Class of the accepted event |
| ret_addr | output | ADDR_W | Resume address |
| cpl | output | 2 | Current privilege level |
| ie | output | 1 | Maskable interrupt enable flag |
| nmi_active | output | 1 | Non-maskable handler in progress |
| irq_ack | output | 1 | Acknowledge to the maskable source |

## Verification
The bench fires a fault, a trap, a non-maskable edge and a maskable request at the same boundary, then retires more instructions until all of them have been accepted. A wrong priority shows up as the wrong class, or as a lost event, at the first or the second step.

It raises a second non-maskable edge and a maskable request while a non-maskable handler runs. It also injects a fault from inside that handler. A design that nests non-maskable handlers would take the edge at once. A design that blocks everything would lose the fault.

Filling the context stack checks that asynchronous events wait while faults still go through. Unwinding the stack checks that `nmi_active` clears only when the non-maskable entry is popped. A final `iret` on an empty stack must leave `cpl` and `ie` untouched.

// File: rtl/evt_pkg.sv
package evt_pkg;

   localparam int VEC_W = 8;
   localparam int CPL_W = 2;
   localparam logic [VEC_W-1:0] NMI_VECTOR = 8'd2;

   // class codes are visible at the port; their values form part of the contract
   typedef enum logic [1:0] {
      CLS_FAULT = 2'd0,
      CLS_TRAP  = 2'd1,
      CLS_NMI   = 2'd2,
      CLS_IRQ   = 2'd3
   } evt_cls_e;

   typedef struct packed {
      logic [CPL_W-1:0] cpl;
      logic             ie;
      logic             nmi;
   } ctx_t;

endpackage

// File: rtl/evt_nmi_latch.sv
module evt_nmi_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic nmi_in,
   input  logic consume,
   output logic nmi_pend
);

   logic prev_q;
   logic pend_q;
   logic rise;

   assign rise     = nmi_in & ~prev_q;
   assign nmi_pend = pend_q | rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         prev_q <= nmi_in;
         pend_q <= nmi_pend & ~consume;
      end
   end

endmodule

// File: rtl/evt_ctx_stack.sv
module evt_ctx_stack
   import evt_pkg::*;
#(
   parameter int DEPTH = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic push,
   input  ctx_t push_ctx,
   input  logic pop,
   output ctx_t top_ctx,
   output logic empty,
   output logic full
);

   localparam int SP_W = $clog2(DEPTH + 1);

   if (DEPTH < 1) begin : g_bad_depth
      $error("evt_ctx_stack: DEPTH must be at least 1");
   end

   logic [SP_W-1:0] sp_q;
   ctx_t            slot_w [DEPTH];
   logic            do_push;
   logic            do_pop;

   assign empty   = (sp_q == '0);
   assign full    = (sp_q == SP_W'(DEPTH));
   assign do_push = push & ~full;
   assign do_pop  = pop & ~empty & ~do_push;

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      ctx_t slot_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slot_q <= '0;
         else if (do_push && sp_q == SP_W'(i))
            slot_q <= push_ctx;
      end
      assign slot_w[i] = slot_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sp_q <= '0;
      else if (do_push)
         sp_q <= sp_q + 1'b1;
      else if (do_pop)
         sp_q <= sp_q - 1'b1;
   end

   always_comb begin
      top_ctx = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (SP_W'(i + 1) == sp_q)
            top_ctx = slot_w[i];
      end
   end

endmodule

// File: rtl/evt_arbiter.sv
module evt_arbiter
   import evt_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              boundary,
   input  logic              fault_vld,
   input  logic [VEC_W-1:0]  fault_vec,
   input  logic              trap_vld,
   input  logic [VEC_W-1:0]  trap_vec,
   input  logic              nmi_pend,
   input  logic              irq_req,
   input  logic [VEC_W-1:0]  irq_vec,
   input  logic              ie,
   input  logic              nmi_active,
   input  logic              full,
   input  logic [ADDR_W-1:0] cur_pc,
   input  logic [ADDR_W-1:0] next_pc,
   output logic              sel_vld,
   output evt_cls_e          sel_cls,
   output logic [VEC_W-1:0]  sel_vec,
   output logic [ADDR_W-1:0] sel_ret
);

   logic async_ok;
   assign async_ok = ~nmi_active & ~full;

   always_comb begin
      sel_vld = 1'b0;
      sel_cls = CLS_FAULT;
      sel_vec = fault_vec;
      sel_ret = cur_pc;
      if (boundary) begin
         if (fault_vld) begin
            sel_vld = 1'b1;
         end else if (trap_vld) begin
            sel_vld = 1'b1;
            sel_cls = CLS_TRAP;
            sel_vec = trap_vec;
            sel_ret = next_pc;
         end else if (nmi_pend && async_ok) begin
            sel_vld = 1'b1;
            sel_cls = CLS_NMI;
            sel_vec = NMI_VECTOR;
            sel_ret = next_pc;
         end else if (irq_req && ie && async_ok) begin
            sel_vld = 1'b1;
            sel_cls = CLS_IRQ;
            sel_vec = irq_vec;
            sel_ret = next_pc;
         end
      end
   end

endmodule

// File: rtl/evt_sequencer.sv
module evt_sequencer
   import evt_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int DEPTH     = 4,
   parameter int RESET_CPL = 3,
   parameter bit RESET_IE  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              retire_vld,
   input  logic [ADDR_W-1:0] cur_pc,
   input  logic [ADDR_W-1:0] next_pc,
   input  logic              fault_vld,
   input  logic [7:0]        fault_vec,
   input  logic              trap_vld,
   input  logic [7:0]        trap_vec,
   input  logic              irq_req,
   input  logic [7:0]        irq_vec,
   input  logic              nmi_in,
   input  logic              iret,
   input  logic              ie_wr,
   input  logic              ie_wdata,
   output logic              take,
   output logic [7:0]        take_vec,
   output logic [1:0]        take_cls,
   output logic [ADDR_W-1:0] ret_addr,
   output logic [1:0]        cpl,
   output logic              ie,
   output logic              nmi_active,
   output logic              irq_ack
);

   if (ADDR_W < 1) begin : g_bad_addr
      $error("evt_sequencer: ADDR_W must be positive");
   end
   if (RESET_CPL < 0 || RESET_CPL >= (1 << CPL_W)) begin : g_bad_cpl
      $error("evt_sequencer: RESET_CPL out of range");
   end

   logic              boundary;
   logic              nmi_pend;
   logic              sel_vld;
   evt_cls_e          sel_cls;
   logic [VEC_W-1:0]  sel_vec;
   logic [ADDR_W-1:0] sel_ret;
   ctx_t              push_ctx;
   ctx_t              top_ctx;
   logic              stk_empty;
   logic              stk_full;
   logic              pop_ok;

   logic              take_q;
   logic              ack_q;
   logic [VEC_W-1:0]  vec_q;
   evt_cls_e          cls_q;
   logic [ADDR_W-1:0] ret_q;
   logic [CPL_W-1:0]  cpl_q;
   logic              ie_q;
   logic              nact_q;

   assign boundary = retire_vld & ~iret;
   assign pop_ok   = iret & ~stk_empty;
   assign push_ctx = '{cpl: cpl_q, ie: ie_q, nmi: (sel_cls == CLS_NMI)};

   evt_nmi_latch u_nmi (
      .clk      (clk),
      .rst_n    (rst_n),
      .nmi_in   (nmi_in),
      .consume  (sel_vld && sel_cls == CLS_NMI),
      .nmi_pend (nmi_pend)
   );

   evt_arbiter #(.ADDR_W(ADDR_W)) u_arb (
      .boundary   (boundary),
      .fault_vld  (fault_vld),
      .fault_vec  (fault_vec),
      .trap_vld   (trap_vld),
      .trap_vec   (trap_vec),
      .nmi_pend   (nmi_pend),
      .irq_req    (irq_req),
      .irq_vec    (irq_vec),
      .ie         (ie_q),
      .nmi_active (nact_q),
      .full       (stk_full),
      .cur_pc     (cur_pc),
      .next_pc    (next_pc),
      .sel_vld    (sel_vld),
      .sel_cls    (sel_cls),
      .sel_vec    (sel_vec),
      .sel_ret    (sel_ret)
   );

   evt_ctx_stack #(.DEPTH(DEPTH)) u_stk (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (sel_vld),
      .push_ctx (push_ctx),
      .pop      (pop_ok),
      .top_ctx  (top_ctx),
      .empty    (stk_empty),
      .full     (stk_full)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         take_q <= 1'b0;
         ack_q  <= 1'b0;
         vec_q  <= '0;
         cls_q  <= CLS_FAULT;
         ret_q  <= '0;
         cpl_q  <= CPL_W'(RESET_CPL);
         ie_q   <= RESET_IE;
         nact_q <= 1'b0;
      end else begin
         take_q <= sel_vld;
         ack_q  <= sel_vld && sel_cls == CLS_IRQ;
         if (sel_vld) begin
            vec_q <= sel_vec;
            cls_q <= sel_cls;
            ret_q <= sel_ret;
            cpl_q <= '0;
            if (sel_cls == CLS_IRQ) ie_q   <= 1'b0;
            if (sel_cls == CLS_NMI) nact_q <= 1'b1;
         end else if (pop_ok) begin
            cpl_q <= top_ctx.cpl;
            ie_q  <= top_ctx.ie;
            if (top_ctx.nmi) nact_q <= 1'b0;
         end else if (ie_wr && !iret) begin
            ie_q <= ie_wdata;
         end
      end
   end

   assign take       = take_q;
   assign irq_ack    = ack_q;
   assign take_vec   = vec_q;
   assign take_cls   = cls_q;
   assign ret_addr   = ret_q;
   assign cpl        = cpl_q;
   assign ie         = ie_q;
   assign nmi_active = nact_q;

endmodule

// File: rtl/evt_sequencer_chk.sv
module evt_sequencer_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              retire_vld,
   input logic              iret,
   input logic [ADDR_W-1:0] cur_pc,
   input logic [ADDR_W-1:0] next_pc,
   input logic              take,
   input logic [7:0]        take_vec,
   input logic [1:0]        take_cls,
   input logic [ADDR_W-1:0] ret_addr,
   input logic [1:0]        cpl,
   input logic              ie,
   input logic              nmi_active,
   input logic              irq_ack
);

   assert_boundary_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> $past(retire_vld && !iret));

   assert_fault_ret_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (take && take_cls == 2'd0) |-> ret_addr == $past(cur_pc));

   assert_trap_ret_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (take && take_cls == 2'd1) |-> ret_addr == $past(next_pc));

   assert_nmi_vector_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (take && take_cls == 2'd2) |-> take_vec == 8'd2);

   assert_irq_needs_ie_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (take && take_cls == 2'd3) |-> $past(ie));

   assert_no_async_nesting_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (take && take_cls[1]) |-> !$past(nmi_active));

   assert_ring_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> cpl == 2'd0);

   assert_irq_clears_ie_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (take && take_cls == 2'd3) |-> !ie);

   assert_ack_with_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |-> (take && take_cls == 2'd3));

   assert_irq_gets_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (take && take_cls == 2'd3) |-> irq_ack);

endmodule

bind evt_sequencer evt_sequencer_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/evt_sequencer_test.sv
module evt_sequencer_test;

   localparam int AW    = 32;
   localparam int DEPTH = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          retire_vld = 0, fault_vld = 0, trap_vld = 0, irq_req = 0;
   logic          nmi_in = 0, iret = 0, ie_wr = 0, ie_wdata = 0;
   logic [AW-1:0] cur_pc = 0, next_pc = 0;
   logic [7:0]    fault_vec = 0, trap_vec = 0, irq_vec = 0;
   logic          take, ie, nmi_active, irq_ack;
   logic [7:0]    take_vec;
   logic [1:0]    take_cls, cpl;
   logic [AW-1:0] ret_addr;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 0;

   always #10 clk = ~clk;

   evt_sequencer #(.ADDR_W(AW), .DEPTH(DEPTH), .RESET_CPL(3), .RESET_IE(1'b0)) uut (.*);

   task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // behavioural reference: context stack as a queue of packed integers
   int m_cpl, m_ie, m_nact, m_pend, m_prev;
   int m_stk[$];
   int e_take, e_ack, e_vec, e_cls, e_ret;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cpl = 3; m_ie = 0; m_nact = 0; m_pend = 0; m_prev = 0;
         m_stk.delete();
         e_take = 0; e_ack = 0; e_vec = 0; e_cls = 0; e_ret = 0;
      end else begin
         int tk;
         int ent;
         if (nmi_in && !m_prev) m_pend = 1;
         m_prev = nmi_in;
         tk = 0;
         e_ack = 0;
         if (iret) begin
            if (m_stk.size() > 0) begin
               ent = m_stk.pop_back();
               m_cpl = ent >> 2;
               m_ie = (ent >> 1) & 1;
               if (ent & 1) m_nact = 0;
            end
         end else if (retire_vld) begin
            if (fault_vld) begin
               tk = 1; e_cls = 0; e_vec = fault_vec; e_ret = cur_pc;
            end else if (trap_vld) begin
               tk = 1; e_cls = 1; e_vec = trap_vec; e_ret = next_pc;
            end else if (m_pend && !m_nact && m_stk.size() < DEPTH) begin
               tk = 1; e_cls = 2; e_vec = 2; e_ret = next_pc; m_pend = 0;
            end else if (irq_req && m_ie && !m_nact && m_stk.size() < DEPTH) begin
               tk = 1; e_cls = 3; e_vec = irq_vec; e_ret = next_pc; e_ack = 1;
            end
            if (tk) begin
               if (m_stk.size() < DEPTH)
                  m_stk.push_back(m_cpl * 4 + m_ie * 2 + (e_cls == 2 ? 1 : 0));
               m_cpl = 0;
               if (e_cls == 3) m_ie = 0;
               if (e_cls == 2) m_nact = 1;
            end
         end
         if (!tk && !iret && ie_wr) m_ie = ie_wdata;
         e_take = tk;
      end
   end

   // compare every cycle, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R13", "take", take, e_take);
         chk("R9",  "irq_ack", irq_ack, e_ack);
         chk("R7",  "cpl", cpl, e_take ? 0 : m_cpl);
         chk("R8",  "ie", ie, m_ie);
         chk("R6",  "nmi_active", nmi_active, m_nact);
         if (e_take) begin
            chk("R2", "take_cls", take_cls, e_cls);
            chk("R4", "take_vec", take_vec, e_vec);
            chk("R3", "ret_addr", ret_addr, e_ret);
         end
      end
   end

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      retire_vld = 0; fault_vld = 0; trap_vld = 0; iret = 0; ie_wr = 0;
   endtask

   task automatic retire(input int c);
      retire_vld = 1; cur_pc = c; next_pc = c + 4;
   endtask

   task automatic finish_run();
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      #4_000_000;
      if (!done) begin
         n_err++; n_chk++;
         $display("FAIL R13 watchdog: actual=timeout expected=completion");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R12 reset state
      chk("R12", "take", take, 0);
      chk("R12", "cpl", cpl, 3);
      chk("R12", "ie", ie, 0);
      chk("R12", "nmi_active", nmi_active, 0);

      // R5 masked request ignored
      irq_req = 1; irq_vec = 8'h41; retire(32'h100); tick();
      chk("R5", "masked take", take, 0);
      ie_wr = 1; ie_wdata = 1; tick();
      chk("R5", "ie write", ie, 1);
      tick();
      chk("R1", "no boundary no take", take, 0);
      retire(32'h100); tick();
      chk("R4", "irq vec", take_vec, 8'h41);
      chk("R3", "irq ret", ret_addr, 32'h104);
      chk("R9", "ack", irq_ack, 1);
      chk("R8", "ie cleared", ie, 0);
      chk("R7", "cpl0", cpl, 0);
      irq_req = 0; tick();
      chk("R13", "pulse ends", take, 0);
      iret = 1; tick();
      chk("R7", "cpl restored", cpl, 3);
      chk("R8", "ie restored", ie, 1);

      // R2 all together
      fault_vld = 1; fault_vec = 8'h0E; trap_vld = 1; trap_vec = 8'h03;
      nmi_in = 1; irq_req = 1; irq_vec = 8'h55; retire(32'h200); tick();
      chk("R2", "fault wins", take_cls, 0);
      chk("R3", "fault ret", ret_addr, 32'h200);
      trap_vld = 1; trap_vec = 8'h80; retire(32'h300); tick();
      chk("R2", "trap next", take_cls, 1);
      chk("R3", "trap ret", ret_addr, 32'h304);
      retire(32'h400); tick();
      chk("R2", "nmi over irq", take_cls, 2);
      chk("R4", "nmi vec", take_vec, 2);
      nmi_in = 0; retire(32'h500); tick();
      chk("R6", "irq blocked", take, 0);
      nmi_in = 1; retire(32'h504); tick();
      chk("R6", "nmi not nested", take, 0);
      fault_vld = 1; fault_vec = 8'h0D; retire(32'h508); tick();
      chk("R6", "fault in nmi", take, 1);
      trap_vld = 1; trap_vec = 8'h04; retire(32'h50C); tick();
      chk("R11", "trap at full", take_cls, 1);
      iret = 1; tick();
      chk("R6", "still active", nmi_active, 1);
      iret = 1; tick();
      chk("R6", "nmi done", nmi_active, 0);
      retire(32'h600); tick();
      chk("R6", "pending nmi taken", take_cls, 2);
      irq_req = 0; iret = 1; tick();
      iret = 1; tick();
      iret = 1; tick();
      chk("R7", "unwound", cpl, 3);
      iret = 1; tick();
      chk("R10", "empty cpl", cpl, 3);
      chk("R10", "empty ie", ie, 1);

      // R11 full stack holds async events
      nmi_in = 0; tick();
      for (int k = 0; k < DEPTH; k++) begin
         fault_vld = 1; fault_vec = 8'h10 + k[7:0]; retire(32'h700 + k * 8); tick();
      end
      nmi_in = 1; irq_req = 1; irq_vec = 8'h66; retire(32'h800); tick();
      chk("R11", "async held", take, 0);
      iret = 1; tick();
      irq_req = 0; retire(32'h900); tick();
      chk("R11", "nmi after room", take_cls, 2);
      for (int k = 0; k < DEPTH; k++) begin
         iret = 1; tick();
      end
      chk("R7", "final cpl", cpl, 3);
      chk("R6", "final nmi", nmi_active, 0);
      tick();
      finish_run();
   end

endmodule